// File: doc/BRIEF.md
# Calibrated Clock Prescaler

This block turns a stream of single-cycle oscillator enables, nominally 32,768 per second, into a one-cycle pulse once per second. A binary prescaler divides the enable stream by 256. Its carry, the correction node, feeds a second-stage counter that divides by 128. The timebase can be trimmed digitally. Within each calibration period of 64 seconds, the first N node pulses are either dropped, which slows the clock, or counted twice, which speeds it up. N is a 5-bit magnitude and a direction bit chooses between the two.

The calibration setting is taken only at the start of a period, so software can rewrite it at any time. The new value takes effect cleanly at the next period boundary. A stop input freezes every counter in place. When stop is released, counting resumes from the held count. A test output shows the divide-by-64 stage of the prescaler as a square wave (512 Hz at nominal input) whenever it is enabled.

All divide ratios and the period length are parameters. The bench uses small values so that several whole calibration periods fit in one run.

Top module: `cal_prescaler`

## Requirements
- R1: While reset is asserted, `sec_tick` and `ftest_out` are 0.
- R2: With magnitude 0, every second lasts exactly 2^PRE_W × SEC_DIV counted enables (32,768 by default).
- R3: `sec_tick` is high for exactly one clock cycle. It rises in the cycle after the clock edge that consumed the enable completing the second.
- R4: With `cal_pos` = 0 (negative), the first N node pulses of each period are blanked. A period then lasts (PERIOD_SECS × SEC_DIV + N) × 2^PRE_W enables.
- R5: With `cal_pos` = 1 (positive), the first N node pulses of each period each advance the second counter by two. For N ≤ PERIOD_SECS × SEC_DIV / 2, a period lasts (PERIOD_SECS × SEC_DIV − N) × 2^PRE_W enables.
- R6: `cal_pos` and `cal_mag` are sampled only in the first cycle after reset and in the cycle after the last second of a period. Changes at any other time have no effect until the next period.
- R7: While `stop` is 1, enables are not counted, `sec_tick` stays 0 and `ftest_out` holds its value. After release, the second completes once the remaining enables arrive.
- R8: Only cycles with `osc_tick` = 1 advance the divider. Idle cycles between enables change nothing.
- R9: With `ftest_en` = 1, `ftest_out` equals bit TEST_BIT of the prescaler count. That bit is 1 after enable count k exactly when (k >> TEST_BIT) & 1 is 1, giving a period of 2^(TEST_BIT+1) enables. With `ftest_en` = 0, `ftest_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle oscillator enable |
| stop | input | 1 | Freezes all counters while 1 |
| cal_pos | input | 1 | Correction direction: 1 adds counts, 0 removes counts |
| cal_mag | input | 5 | Correction magnitude N per period |
| ftest_en | input | 1 | Enables the test-frequency output |
| sec_tick | output | 1 | One-cycle pulse per second |
| ftest_out | output | 1 | Prescaler tap square wave, gated by ftest_en |

## Verification
The hardest situation to reach is the period boundary. At that point a new calibration value must be picked up, and the correction count must restart, while a setting written mid-period stays dormant. At default sizes that boundary is two million enables away.

The bench instantiates the block with a 16-enable prescaler, 8 node pulses per second and 4-second periods. Whole periods are then a few hundred cycles long. The bench changes the setting partway through the first period and measures the enable count at the fourth and eighth ticks. The largest negative magnitude is also run, so that the blanking spans several seconds.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int CAL_MAG_W = 5;

  typedef struct packed {
    logic                 pos;
    logic [CAL_MAG_W-1:0] mag;
  } cal_t;

  // Weight a node pulse contributes to the second counter.
  function automatic logic [1:0] node_weight(input logic node, input logic corr,
                                             input logic pos);
    if (!node) return 2'd0;
    if (!corr) return 2'd1;
    return pos ? 2'd2 : 2'd0;
  endfunction
endpackage

// File: rtl/cps_prescaler.sv
module cps_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PRE_W-1:0] pre_q,
  output logic             node_pulse
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  assign node_pulse = adv && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)   pre_q <= '0;
    else if (adv) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cps_sec_count.sv
module cps_sec_count #(
  parameter int SEC_DIV = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] inc,
  output logic       sec_carry,
  output logic       sec_tick
);
  localparam int SEC_W = (SEC_DIV > 2) ? $clog2(SEC_DIV) : 1;
  localparam int SW1   = SEC_W + 1;
  localparam logic [SW1-1:0] DIV_V = SW1'(SEC_DIV);

  logic [SEC_W-1:0] cnt_q;
  logic [SW1-1:0]   sum;
  logic [SW1-1:0]   wrapped;

  always_comb begin
    sum       = {1'b0, cnt_q} + SW1'(inc);
    sec_carry = (sum >= DIV_V);
    wrapped   = sec_carry ? (sum - DIV_V) : sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sec_tick <= 1'b0;
    end else begin
      cnt_q    <= wrapped[SEC_W-1:0];
      sec_tick <= sec_carry;
    end
  end
endmodule

// File: rtl/cps_cal_sched.sv
module cps_cal_sched
  import cps_pkg::*;
#(
  parameter int PERIOD_SECS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 node_pulse,
  input  logic                 sec_carry,
  input  cal_t                 cal_in,
  output logic                 corr_now,
  output logic                 arm_q,
  output cal_t                 cal_q,
  output logic [CAL_MAG_W-1:0] fix_q
);
  localparam int PER_W = (PERIOD_SECS > 2) ? $clog2(PERIOD_SECS) : 1;
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(PERIOD_SECS - 1);

  logic [PER_W-1:0] per_q;
  logic             last_sec;

  assign last_sec = sec_carry && (per_q == PER_LAST);
  assign corr_now = node_pulse && !arm_q && (fix_q < cal_q.mag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q <= '0;
      arm_q <= 1'b1;
      cal_q <= '0;
      fix_q <= '0;
    end else begin
      arm_q <= last_sec;
      if (last_sec)       per_q <= '0;
      else if (sec_carry) per_q <= per_q + 1'b1;
      if (arm_q) begin
        cal_q <= cal_in;
        fix_q <= '0;
      end else if (corr_now) begin
        fix_q <= fix_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler
  import cps_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int SEC_DIV     = 128,
  parameter int PERIOD_SECS = 64,
  parameter int TEST_BIT    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 osc_tick,
  input  logic                 stop,
  input  logic                 cal_pos,
  input  logic [CAL_MAG_W-1:0] cal_mag,
  input  logic                 ftest_en,
  output logic                 sec_tick,
  output logic                 ftest_out
);
  logic                 adv;
  logic [PRE_W-1:0]     pre_q;
  logic                 node_pulse;
  logic                 corr_now;
  logic                 arm_q;
  logic                 sec_carry;
  logic [1:0]           inc;
  cal_t                 cal_in;
  cal_t                 cal_q;
  logic [CAL_MAG_W-1:0] fix_q;

  assign adv    = osc_tick && !stop;
  assign cal_in = '{pos: cal_pos, mag: cal_mag};
  assign inc    = node_weight(node_pulse, corr_now, cal_q.pos);

  cps_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .adv(adv), .pre_q(pre_q), .node_pulse(node_pulse)
  );

  cps_cal_sched #(.PERIOD_SECS(PERIOD_SECS)) u_sched (
    .clk(clk), .rst_n(rst_n), .node_pulse(node_pulse), .sec_carry(sec_carry),
    .cal_in(cal_in), .corr_now(corr_now), .arm_q(arm_q), .cal_q(cal_q), .fix_q(fix_q)
  );

  cps_sec_count #(.SEC_DIV(SEC_DIV)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(inc), .sec_carry(sec_carry), .sec_tick(sec_tick)
  );

  assign ftest_out = ftest_en && pre_q[TEST_BIT];
endmodule

// File: rtl/cps_chk.sv
module cps_chk
  import cps_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 osc_tick,
  input logic                 stop,
  input logic                 sec_tick,
  input logic [PRE_W-1:0]     pre_q,
  input logic                 arm_q,
  input cal_t                 cal_q,
  input logic [CAL_MAG_W-1:0] fix_q
);
  p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  p_stop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sec_tick);

  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> $stable(pre_q));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> $stable(pre_q));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_q |=> $stable(cal_q));

  p_fix_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fix_q <= cal_q.mag);
endmodule

bind cal_prescaler cps_chk #(.PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .stop(stop), .sec_tick(sec_tick),
  .pre_q(pre_q), .arm_q(arm_q), .cal_q(cal_q), .fix_q(fix_q)
);

// File: tb/tb_cal_prescaler.sv
module tb_cal_prescaler;
  localparam int PW = 4;    // 16 enables per node pulse
  localparam int SD = 8;    // 8 node pulses per second
  localparam int PS = 4;    // 4-second calibration period
  localparam int TB = 2;    // test tap bit

  typedef struct packed {
    logic        pos;
    logic [4:0]  mag;
    int unsigned first;
    int unsigned period;
  } vec_t;

  // period = (PS*SD -/+ N) * 16 ; first second hand-derived
  localparam vec_t VEC [6] = '{
    '{pos: 1'b0, mag: 5'd0,  first: 128, period: 512},
    '{pos: 1'b0, mag: 5'd2,  first: 160, period: 544},
    '{pos: 1'b1, mag: 5'd3,  first: 80,  period: 464},
    '{pos: 1'b1, mag: 5'd5,  first: 64,  period: 432},
    '{pos: 1'b0, mag: 5'd31, first: 624, period: 1008},
    '{pos: 1'b1, mag: 5'd16, first: 64,  period: 256}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       stop = 1'b0;
  logic       cal_pos = 1'b0;
  logic [4:0] cal_mag = 5'd0;
  logic       ftest_en = 1'b0;
  wire        sec_tick;
  wire        ftest_out;

  int checks = 0;
  int errors = 0;
  int tcnt = 0;
  int phase = 0;
  int osc_mode = 0;

  always #2 clk = ~clk;

  cal_prescaler #(.PRE_W(PW), .SEC_DIV(SD), .PERIOD_SECS(PS), .TEST_BIT(TB)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .stop(stop), .cal_pos(cal_pos),
    .cal_mag(cal_mag), .ftest_en(ftest_en), .sec_tick(sec_tick), .ftest_out(ftest_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_osc();
    osc_tick = (osc_mode == 0) ? 1'b1 : (phase == 0);
  endtask

  task automatic step();
    @(posedge clk);
    if (osc_tick && !stop) tcnt++;
    #1;
    phase = (phase + 1) % 3;
    set_osc();
  endtask

  task automatic do_reset(input logic p, input logic [4:0] m);
    rst_n = 1'b0; cal_pos = p; cal_mag = m; stop = 1'b0;
    repeat (3) step();
    check("R1", "sec_tick in reset", int'(sec_tick), 0);
    check("R1", "ftest_out in reset", int'(ftest_out), 0);
    rst_n = 1'b1; tcnt = 0; phase = 0; set_osc();
  endtask

  task automatic wait_secs(input int n, output int at_first, output int at_last);
    int seen = 0;
    int guard = 0;
    at_first = -1; at_last = -1;
    while (seen < n && guard < 20000) begin
      step();
      guard++;
      if (sec_tick) begin
        seen++;
        if (seen == 1) at_first = tcnt;
        at_last = tcnt;
      end
    end
  endtask

  initial begin
    #700000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f, l, f2, l2, cnt, hold_v;
    string req;
    // Table walk: R2 / R4 / R5
    for (int i = 0; i < 6; i++) begin
      req = (VEC[i].mag == 0) ? "R2" : (VEC[i].pos ? "R5" : "R4");
      do_reset(VEC[i].pos, VEC[i].mag);
      wait_secs(PS, f, l);
      check(req, "first second enables", f, int'(VEC[i].first));
      check(req, "first period enables", l, int'(VEC[i].period));
      wait_secs(PS, f2, l2);
      check(req, "second period enables", l2, 2 * int'(VEC[i].period));
    end

    // R3: exact tick timing and single-cycle width
    do_reset(1'b0, 5'd0);
    wait_secs(1, f, l);
    check("R3", "tick at enable", f, 128);
    step();
    check("R3", "tick width", int'(sec_tick), 0);

    // R6: mid-period change is dormant until the boundary
    do_reset(1'b0, 5'd0);
    while (tcnt < 100) step();
    cal_pos = 1'b1; cal_mag = 5'd4;
    wait_secs(PS, f, l);
    check("R6", "old setting kept", l, 512);
    wait_secs(PS, f, l);
    check("R6", "new setting at boundary", l, 512 + 28 * 16);

    // R7: stop freezes counting and outputs
    ftest_en = 1'b1;
    do_reset(1'b0, 5'd0);
    while (tcnt < 50) step();
    stop = 1'b1;
    hold_v = int'(ftest_out);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      if (sec_tick || (int'(ftest_out) != hold_v)) cnt++;
    end
    check("R7", "activity while stopped", cnt, 0);
    stop = 1'b0;
    wait_secs(1, f, l);
    check("R7", "second after resume", f, 128);

    // R9: test tap follows enable count, off when disabled
    do_reset(1'b0, 5'd0);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      if (int'(ftest_out) != ((tcnt >> TB) & 1)) cnt++;
    end
    check("R9", "tap mismatches", cnt, 0);
    ftest_en = 1'b0;
    cnt = 0;
    for (int k = 0; k < 12; k++) begin
      step();
      if (ftest_out) cnt++;
    end
    check("R9", "tap high while disabled", cnt, 0);

    // R8: sparse enables, one every third cycle
    osc_mode = 1;
    do_reset(1'b0, 5'd0);
    wait_secs(1, f, l);
    check("R8", "sparse second enables", f, 128);
    osc_mode = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule